// File: doc/BRIEF.md
# Centre-Aligned PWM Timer

This block is a timer/counter that sweeps its count up from zero to its maximum value and back down again, producing a single waveform output whose pulses are centred on the bottom of the sweep. Software supplies a compare threshold, a 2-bit output mode and a clock-divide selection. The timer generates a PWM output from these, along with a bottom-reached flag and a compare-hit flag. Each flag is cleared by its own strobe.

The compare threshold is written into a holding register. It becomes active only when the count arrives at the top of the sweep, so every down-then-up half-cycle pair around the bottom uses a single threshold. The output is not a plain set/clear on matches. At the top and bottom of the sweep, the level is forced to the value the matches would have produced. This keeps the waveform symmetric about the bottom when the threshold jumps or when a match is skipped. Leaving the full-scale threshold therefore produces a falling edge at the top without any match.

With the default 8-bit count, a full cycle takes 510 counter steps. The output frequency is the clock divided by (prescale factor × 510).

Top module: `pwm_dualslope`

## Requirements
- R1: After reset the count steps by one on every counter tick. It climbs 0,1,...,MAX and then falls MAX-1,...,1,0, repeating with a period of 2×MAX ticks. MAX is 2^CNT_W−1. `count` shows the registered count.
- R2: A counter tick occurs on every N-th clock in which `en` is high and `clk_sel` is valid. The values are `clk_sel`=1→N=1, 2→8, 3→64, 4→256, 5→1024. `clk_sel` values 0, 6 and 7 stop the counter. When `en` is low or the selection is invalid, the divider phase restarts, so the first tick comes on the N-th qualifying clock afterwards.
- R3: `ovf_flag` is set on the tick on which the count arrives at 0. It stays set until `clr_ovf` is high in a cycle without a new set. A set wins over a simultaneous clear.
- R4: `cmp_flag` is set on any tick on which the count arrives at the active threshold, in either direction. It holds and clears through `clr_cmp` with the same rules as R3.
- R5: A write (`cmp_wr` high with `cmp_wdata`) updates only the holding register. The active threshold takes the holding value on the tick on which the count arrives at MAX. Its reset value is 0.
- R6: In mode 2 (`cmp_mode`=2) with an active threshold C where 0<C<MAX, the output goes low on the tick that arrives at C while counting up. It goes high on the tick that arrives at C while counting down.
- R7: Mode 3 gives exactly the inverse of the mode-2 level.
- R8: In mode 2, an active threshold of 0 holds the output low and a threshold of MAX holds it high. Mode 3 gives the opposite levels.
- R9: On the tick arriving at MAX with 0<C<MAX, the mode-2 level is forced low, which is the up-match level. This applies even with no match, for example when the threshold has just left MAX. On arrival at 0 the level is forced high.
- R10: Modes 0 and 1 hold `pwm_out` low. The internal level keeps tracking, so switching to mode 2 or 3 takes effect on the next clock.
- R11: While `rst` is high at a clock edge, the count, direction (up), both flags, the holding register, the active threshold and `pwm_out` all return to zero or their idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| clk_sel | input | 3 | Prescale selection (1,8,64,256,1024; others stop) |
| cmp_mode | input | 2 | Output mode: 0/1 low, 2 non-inverted, 3 inverted |
| cmp_wr | input | 1 | Threshold write strobe |
| cmp_wdata | input | CNT_W | Threshold write value |
| clr_ovf | input | 1 | Clear strobe for ovf_flag |
| clr_cmp | input | 1 | Clear strobe for cmp_flag |
| pwm_out | output | 1 | Registered waveform output |
| ovf_flag | output | 1 | Bottom-reached flag |
| cmp_flag | output | 1 | Compare-hit flag |
| count | output | CNT_W | Current count |

## Verification
The bench builds the timer with CNT_W=4, giving a maximum of 15 and a cycle of 30 ticks. At that size, every threshold from 0 to 15 in every output mode runs through complete cycles. This includes the jumps away from and onto full scale, within a few thousand clocks. The same small count also allows each prescale selection, including divide-by-1024, to run for many ticks. In addition, the bench toggles enable, sends clear strobes irregularly and applies a mid-run reset.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_RSVD   = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_t;

  localparam int PRE_W = 10;

  // Low-bit mask of the prescale counter for a given selection; valid=0 stops
  function automatic logic [PRE_W:0] div_mask(input logic [2:0] sel);
    logic [PRE_W:0] r;
    case (sel)
      3'd1:    r = {1'b1, 10'd0};
      3'd2:    r = {1'b1, 10'd7};
      3'd3:    r = {1'b1, 10'd63};
      3'd4:    r = {1'b1, 10'd255};
      3'd5:    r = {1'b1, 10'd1023};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pwm_ds_prescaler.sv
module pwm_ds_prescaler
  import pwm_ds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pc;
  logic [PRE_W:0]   sel_info;
  logic             run;

  always_comb begin
    sel_info = div_mask(sel);
    run      = en && sel_info[PRE_W];
    tick     = run && ((pc & sel_info[PRE_W-1:0]) == sel_info[PRE_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pc <= '0;
    else             pc <= pc + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_ds_counter.sv
module pwm_ds_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             arr_up
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic dir_up;

  always_comb begin
    arr_up  = dir_up;
    cnt_nxt = dir_up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      cnt    <= cnt_nxt;
      dir_up <= dir_up ? (cnt_nxt != TOP) : (cnt_nxt == '0);
    end
  end
endmodule

// File: rtl/pwm_ds_compare.sv
module pwm_ds_compare
  import pwm_ds_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             arr_up,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [1:0]       mode,
  output logic             match,
  output logic [CNT_W-1:0] thr_act,
  output logic             pwm_out
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] thr_hold;
  logic [CNT_W-1:0] thr_new;
  logic             lvl, lvl_nxt;
  out_mode_t        m;

  always_comb begin
    m       = out_mode_t'(mode);
    thr_new = (tick && cnt_nxt == TOP) ? thr_hold : thr_act;
    match   = tick && (cnt_nxt == thr_new);
    lvl_nxt = lvl;
    if (tick) begin
      if (thr_new == '0)        lvl_nxt = 1'b0;
      else if (thr_new == TOP)  lvl_nxt = 1'b1;
      else if (cnt_nxt == TOP)  lvl_nxt = 1'b0;
      else if (cnt_nxt == '0)   lvl_nxt = 1'b1;
      else if (match)           lvl_nxt = !arr_up;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_hold <= '0;
      thr_act  <= '0;
      lvl      <= 1'b0;
      pwm_out  <= 1'b0;
    end else begin
      if (wr) thr_hold <= wdata;
      thr_act <= thr_new;
      lvl     <= lvl_nxt;
      case (m)
        OUT_NONINV: pwm_out <= lvl_nxt;
        OUT_INV:    pwm_out <= !lvl_nxt;
        default:    pwm_out <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_dualslope.sv
module pwm_dualslope #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       clk_sel,
  input  logic [1:0]       cmp_mode,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             clr_ovf,
  input  logic             clr_cmp,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic [CNT_W-1:0] count
);
  logic             tick;
  logic [CNT_W-1:0] cnt_nxt;
  logic             arr_up;
  logic             match;
  logic [CNT_W-1:0] cmp_act;
  logic             bottom_hit;

  pwm_ds_prescaler u_pre (
    .clk(clk), .rst(rst), .en(en), .sel(clk_sel), .tick(tick)
  );

  pwm_ds_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt(count), .cnt_nxt(cnt_nxt), .arr_up(arr_up)
  );

  pwm_ds_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .tick(tick), .cnt_nxt(cnt_nxt), .arr_up(arr_up),
    .wr(cmp_wr), .wdata(cmp_wdata), .mode(cmp_mode),
    .match(match), .thr_act(cmp_act), .pwm_out(pwm_out)
  );

  assign bottom_hit = tick && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= bottom_hit || (ovf_flag && !clr_ovf);
      cmp_flag <= match      || (cmp_flag && !clr_cmp);
    end
  end
endmodule

// File: rtl/pwm_ds_checker.sv
module pwm_ds_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_act,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic             clr_ovf,
  input logic             clr_cmp,
  input logic             pwm_out,
  input logic [1:0]       cmp_mode
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_unit_step_r1: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |->
      (count == $past(count) + CNT_W'(1) || count == $past(count) - CNT_W'(1)));

  p_ovf_at_bottom_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (count == '0));

  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  p_cmp_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !clr_cmp) |=> cmp_flag);

  p_cmp_at_thr_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> (count == cmp_act));

  p_load_at_top_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmp_act) |-> (count == TOP));

  p_mode_off_low_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode[1] == 1'b0) |=> !pwm_out);
endmodule

bind pwm_dualslope pwm_ds_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pwm_dualslope.sv
module tb_pwm_dualslope;
  localparam int CW = 4;
  localparam int MX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [2:0]    clk_sel = 3'd1;
  logic [1:0]    cmp_mode = 2'd0;
  logic          cmp_wr = 1'b0;
  logic [CW-1:0] cmp_wdata = '0;
  logic          clr_ovf = 1'b0;
  logic          clr_cmp = 1'b0;
  logic          pwm_out, ovf_flag, cmp_flag;
  logic [CW-1:0] count;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // reference state
  int pcm, cntm, thr_hold, thr_act;
  bit upm, lastup, stepped, ovfm, cmpm, outm;

  always #4 clk = ~clk;

  pwm_dualslope #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .en(en), .clk_sel(clk_sel), .cmp_mode(cmp_mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .clr_ovf(clr_ovf), .clr_cmp(clr_cmp),
    .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .count(count)
  );

  function automatic int div_of(int s);
    case (s)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic bit level_of(int n, bit up, int c);
    if (c == 0)  return 1'b0;
    if (c == MX) return 1'b1;
    if (up)      return n < c;
    return n <= c;
  endfunction

  task automatic model_edge();
    int  nd, n;
    bit  tk, lv;
    if (rst) begin
      pcm = 0; cntm = 0; upm = 1; lastup = 1; stepped = 0;
      thr_hold = 0; thr_act = 0; ovfm = 0; cmpm = 0; outm = 0;
      return;
    end
    nd = en ? div_of(int'(clk_sel)) : 0;
    tk = 0;
    if (nd > 0) begin
      tk  = (pcm % nd) == nd - 1;
      pcm = (pcm + 1) % 1024;
    end else pcm = 0;
    if (tk) begin
      n = upm ? cntm + 1 : cntm - 1;
      lastup = upm;
      if (n == MX) thr_act = thr_hold;
      upm = upm ? (n != MX) : (n == 0);
      cntm = n;
      stepped = 1;
      ovfm = (n == 0) ? 1'b1 : (clr_ovf ? 1'b0 : ovfm);
      cmpm = (n == thr_act) ? 1'b1 : (clr_cmp ? 1'b0 : cmpm);
    end else begin
      if (clr_ovf) ovfm = 0;
      if (clr_cmp) cmpm = 0;
    end
    if (cmp_wr) thr_hold = int'(cmp_wdata);
    lv = stepped ? level_of(cntm, lastup, thr_act) : 1'b0;
    outm = (cmp_mode == 2'd2) ? lv : (cmp_mode == 2'd3) ? !lv : 1'b0;
  endtask

  task automatic cmp_field(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    string ptag;
    if (cmp_mode < 2)                         ptag = "R10 pwm";
    else if (thr_act == 0 || thr_act == MX)   ptag = "R8 pwm";
    else if (cntm == MX || cntm == 0)         ptag = "R9 pwm";
    else if (cmp_mode == 2'd3)                ptag = "R7 pwm";
    else                                      ptag = "R6 pwm";
    cmp_field("R1/R2 count", int'(count), cntm);
    cmp_field("R3 ovf_flag", int'(ovf_flag), int'(ovfm));
    cmp_field("R4/R5 cmp_flag", int'(cmp_flag), int'(cmpm));
    cmp_field(ptag, int'(pwm_out), int'(outm));
  endtask

  // one clock: inputs are already set; random clear strobes
  task automatic run(int ncyc, bit rnd_clr = 1);
    for (int i = 0; i < ncyc; i++) begin
      if (done) return;
      if (rnd_clr) begin
        clr_ovf = ($urandom % 9) == 0;
        clr_cmp = ($urandom % 7) == 0;
      end
      model_edge();
      @(posedge clk);
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic write_thr(int v);
    cmp_wdata = CW'(v);
    cmp_wr = 1'b1;
    run(1);
    cmp_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    rst = 1'b1;
    run(3, 0);
    cmp_field("R11 reset count", int'(count), 0);
    cmp_field("R11 reset pwm", int'(pwm_out), 0);
    rst = 1'b0;
    en = 1'b1; clk_sel = 3'd1;

    // R6 R7 R8 R9 R10: every threshold in every mode, full cycles
    for (int md = 0; md < 4; md++) begin
      cmp_mode = 2'(md);
      for (int c = 0; c <= MX; c++) begin
        write_thr(c);
        run(2 * 2 * MX + 3);
      end
    end

    // R9: leave full scale, falling edge at the top without a match
    cmp_mode = 2'd2;
    write_thr(MX);
    run(4 * MX);
    write_thr(6);
    run(3 * MX);
    // R5: several writes within one cycle, only the last one counts
    write_thr(2);
    run(5);
    write_thr(11);
    run(3);
    write_thr(9);
    run(4 * MX);

    // R10: mode switch takes effect next clock without a tick
    clk_sel = 3'd3;
    cmp_mode = 2'd0; run(20);
    cmp_mode = 2'd3; run(20);
    cmp_mode = 2'd2; run(20);

    // R2: every divide selection, and enable gating
    for (int s = 0; s < 8; s++) begin
      int nd;
      clk_sel = 3'(s);
      nd = div_of(s);
      if (nd == 0) run(200);
      else run(nd * 33 + 5);
      en = 1'b0; run(37);
      en = 1'b1;
    end

    // R11: reset in the middle of activity
    clk_sel = 3'd1;
    run(17);
    rst = 1'b1; run(2, 0);
    cmp_field("R11 mid reset ovf", int'(ovf_flag), 0);
    cmp_field("R11 mid reset cmp", int'(cmp_flag), 0);
    rst = 1'b0;
    write_thr(5);
    run(4 * MX);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule